// File: doc/BRIEF.md
# Shared-Output-Enable Byte Memory Read Controller

This controller sits between a simple host request port and a bank of asynchronous byte-wide read-only memories. The upper bits of the host address pick one device in the bank. Only that device gets an active-low chip enable. Every other device keeps its enable high and stays in its low-power standby state. A single active-low output-enable line is wired to every device in the bank. The controller pulls it low only during the read phase of an access.

Each access is timed by whole clock cycles. The controller selects the device and drives the address first. It waits until output enable can be asserted without cutting into the address and enable access times, holds output enable low for the output-enable access time, and then samples the data bus. On that same edge, chip enable and output enable return high, and the byte goes back to the host with a one-cycle valid pulse. The controller then blocks any access to a different device until the released device's outputs have had their float time to leave the bus.

Top module: `byte_mem_reader`

## Requirements
- R1: Address bits [DEV_ADDR_W+SEL_W-1:DEV_ADDR_W] select the device. During an access, only the memCeN bit at that index is 0 and all other bits are 1. While idle, every bit is 1.
- R2: memOeN is a single line shared by all devices. It is 0 only during the read phase of an access, and only while one memCeN bit is 0.
- R3: memCeN stays low for exactly max(address-time cycles, enable-time cycles) clock cycles. memOeN is low for the last output-enable-time cycles of that window. memData is sampled on the edge that closes the window, and memCeN and memOeN return high on that same edge.
- R4: Each nanosecond delay is converted to cycles by rounding up to a whole clock cycle. With a 10 ns clock, 45 ns becomes 5 cycles and 25 ns becomes 3 cycles.
- R5: rspValid is high for exactly one cycle, in the cycle after the sampling edge. rspData carries the sampled byte and holds it afterwards.
- R6: reqReady is 0 from the accept edge until the sampling edge.
- R7: After a release, an access to a different device does not pull its enable low until memCeN has been all ones for at least the float-time cycles. An access to the same device may be accepted in the cycle right after the response.
- R8: memAddr carries the low DEV_ADDR_W request bits and does not change while any enable is low. While reset is held, memAddr is 0, memCeN is all ones, memOeN is 1 and rspValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host read request |
| reqReady | output | 1 | Request accepted on this edge when reqValid is also high |
| reqAddr | input | DEV_ADDR_W+SEL_W | Host byte address: upper bits pick the device |
| rspValid | output | 1 | One-cycle pulse: rspData is valid |
| rspData | output | DATA_W | Byte read from the bank |
| memAddr | output | DEV_ADDR_W | Address to all devices |
| memCeN | output | NUM_DEV | Per-device chip enable, active low |
| memOeN | output | 1 | Shared output enable, active low |
| memData | input | DATA_W | Shared data bus from the devices |

## Verification
The bench uses four devices with eight address bits each and a 10 ns clock. The delays are 45 ns for address and enable access, 25 ns for output-enable access and 25 ns for float. These round up to a 5-cycle enable window, a 3-cycle output-enable phase that starts two cycles after the enable, and a 3-cycle float gap, so the rounding of 45 ns is exercised along with a non-zero lead before output enable. The bench memory model returns a garbage byte unless every analog delay has really elapsed. Because of this, an access window that is one cycle too short, or a device decode error, shows up as wrong data. Pairs of back-to-back reads reach both the same-device fast path and the different-device float block.

// File: rtl/bmr_pkg.sv
`timescale 1ns/1ps
package bmr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_OE   = 2'd2
  } bmrState_t;

  // Strobes from control to datapath, each marks the edge where it acts
  typedef struct packed {
    logic accept;   // latch address, select device
    logic oeOn;     // pull the shared output enable low
    logic capture;  // sample data, release enables, respond
  } bmrStrobe_t;

endpackage

// File: rtl/bmr_ctrl.sv
`timescale 1ns/1ps
module bmr_ctrl
  import bmr_pkg::*;
#(
  parameter int LEAD_CYC   = 2,
  parameter int OE_CYC     = 3,
  parameter int FLOAT_LOAD = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       sameDev,
  output logic       reqReady,
  output bmrStrobe_t strobe
);

  localparam int PHASE_MAX = (LEAD_CYC > OE_CYC) ? LEAD_CYC : OE_CYC;
  localparam int CNT_W     = (PHASE_MAX > 1) ? $clog2(PHASE_MAX + 1) : 1;
  localparam int FL_W      = (FLOAT_LOAD > 1) ? $clog2(FLOAT_LOAD + 1) : 1;
  localparam int TOTAL     = LEAD_CYC + OE_CYC;
  localparam int TW        = $clog2(TOTAL + 1) + 1;

  bmrState_t        state;
  logic [CNT_W-1:0] phaseCnt;
  logic [FL_W-1:0]  floatCnt;
  logic             accept;

  always_comb begin
    reqReady       = (state == ST_IDLE) && ((floatCnt == '0) || sameDev);
    accept         = reqValid && reqReady;
    strobe.accept  = accept;
    strobe.oeOn    = (accept && (LEAD_CYC == 0)) ||
                     ((state == ST_LEAD) && (phaseCnt == '0));
    strobe.capture = (state == ST_OE) && (phaseCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      floatCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (floatCnt != '0) floatCnt <= floatCnt - 1'b1;
          if (accept) begin
            if (LEAD_CYC == 0) begin
              state    <= ST_OE;
              phaseCnt <= CNT_W'(OE_CYC - 1);
            end else begin
              state    <= ST_LEAD;
              phaseCnt <= CNT_W'(LEAD_CYC - 1);
            end
          end
        end
        ST_LEAD: begin
          if (phaseCnt == '0) begin
            state    <= ST_OE;
            phaseCnt <= CNT_W'(OE_CYC - 1);
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_OE: begin
          if (phaseCnt == '0) begin
            state    <= ST_IDLE;
            floatCnt <= FL_W'(FLOAT_LOAD);
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker: edges since the last accept, saturating
  logic [TW-1:0] sinceAcc;
  always_ff @(posedge clk) begin
    if (rst)                 sinceAcc <= '1;
    else if (accept)         sinceAcc <= '0;
    else if (sinceAcc != '1) sinceAcc <= sinceAcc + 1'b1;
  end

  // R3: sampling happens exactly one full access window after the accept
  p_sample_window_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |-> (sinceAcc == TW'(TOTAL - 1)));

  // R6: no further accept while an access is in flight
  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.accept |=> !reqReady);

endmodule

// File: rtl/bmr_dpath.sv
`timescale 1ns/1ps
module bmr_dpath
  import bmr_pkg::*;
#(
  parameter int NUM_DEV    = 4,
  parameter int SEL_W      = 2,
  parameter int DEV_ADDR_W = 8,
  parameter int DATA_W     = 8,
  parameter int FLOAT_CYC  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DEV_ADDR_W+SEL_W-1:0] reqAddr,
  input  bmrStrobe_t                  strobe,
  input  logic [DATA_W-1:0]           memData,
  output logic                        sameDev,
  output logic [DEV_ADDR_W-1:0]       memAddr,
  output logic [NUM_DEV-1:0]          memCeN,
  output logic                        memOeN,
  output logic                        rspValid,
  output logic [DATA_W-1:0]           rspData
);

  localparam int ADDR_W   = DEV_ADDR_W + SEL_W;
  localparam int IR_W     = (FLOAT_CYC > 1) ? $clog2(FLOAT_CYC + 1) : 1;
  localparam int FLOAT_LO = (FLOAT_CYC > 0) ? FLOAT_CYC - 1 : 0;

  logic [SEL_W-1:0]   reqDev;
  logic [SEL_W-1:0]   curDev;
  logic [NUM_DEV-1:0] selOneHot;

  assign reqDev  = reqAddr[ADDR_W-1 -: SEL_W];
  assign sameDev = (reqDev == curDev);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dec
    assign selOneHot[g] = (reqDev == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curDev   <= '0;
      memAddr  <= '0;
      memCeN   <= '1;
      memOeN   <= 1'b1;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.accept) begin
        curDev  <= reqDev;
        memAddr <= reqAddr[DEV_ADDR_W-1:0];
        memCeN  <= ~selOneHot;
      end else if (strobe.capture) begin
        memCeN  <= '1;
      end
      if (strobe.oeOn)         memOeN <= 1'b0;
      else if (strobe.capture) memOeN <= 1'b1;
      if (strobe.capture)      rspData <= memData;
    end
  end

  // Checker: cycles the bank has spent fully deselected, saturating
  logic [IR_W-1:0] idleRun;
  always_ff @(posedge clk) begin
    if (rst)                              idleRun <= IR_W'(FLOAT_CYC);
    else if (!(&memCeN))                  idleRun <= '0;
    else if (idleRun < IR_W'(FLOAT_CYC))  idleRun <= idleRun + 1'b1;
  end

  // R1: never more than one device selected
  p_one_device_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~memCeN));

  // R2: shared output enable only while a device is selected
  p_oe_needs_ce_r2: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> !(&memCeN));

  // R5: response valid is a single-cycle pulse
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

  // R7: a different device only after the float gap
  p_float_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.accept && !sameDev) |-> (idleRun >= IR_W'(FLOAT_LO)));

  // R8: address frozen while any device is enabled
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(&memCeN) |=> $stable(memAddr));

endmodule

// File: rtl/byte_mem_reader.sv
`timescale 1ns/1ps
module byte_mem_reader
  import bmr_pkg::*;
#(
  parameter int NUM_DEV     = 4,
  parameter int DEV_ADDR_W  = 8,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 10,
  parameter int T_ADDR_NS   = 45,
  parameter int T_CE_NS     = 45,
  parameter int T_OE_NS     = 25,
  parameter int T_FLOAT_NS  = 25,
  localparam int SEL_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int ADDR_W     = DEV_ADDR_W + SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspData,
  output logic [DEV_ADDR_W-1:0] memAddr,
  output logic [NUM_DEV-1:0]    memCeN,
  output logic                  memOeN,
  input  logic [DATA_W-1:0]     memData
);

  localparam int ADDR_CYC   = (T_ADDR_NS + CLK_NS - 1) / CLK_NS;
  localparam int CE_CYC     = (T_CE_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_RAW     = (T_OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_CYC     = (OE_RAW > 0) ? OE_RAW : 1;
  localparam int DF_CYC     = (T_FLOAT_NS + CLK_NS - 1) / CLK_NS;
  localparam int WIN_CYC    = (ADDR_CYC > CE_CYC) ? ADDR_CYC : CE_CYC;
  localparam int LEAD_CYC   = (WIN_CYC > OE_CYC) ? WIN_CYC - OE_CYC : 0;
  localparam int FLOAT_LOAD = (DF_CYC > 0) ? DF_CYC - 1 : 0;

  bmrStrobe_t strobe;
  logic       sameDev;

  bmr_ctrl #(
    .LEAD_CYC   (LEAD_CYC),
    .OE_CYC     (OE_CYC),
    .FLOAT_LOAD (FLOAT_LOAD)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .sameDev  (sameDev),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  bmr_dpath #(
    .NUM_DEV    (NUM_DEV),
    .SEL_W      (SEL_W),
    .DEV_ADDR_W (DEV_ADDR_W),
    .DATA_W     (DATA_W),
    .FLOAT_CYC  (DF_CYC)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .reqAddr  (reqAddr),
    .strobe   (strobe),
    .memData  (memData),
    .sameDev  (sameDev),
    .memAddr  (memAddr),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

endmodule

// File: tb/byte_mem_reader_bench.sv
`timescale 1ns/1ps
module byte_mem_reader_bench;

  localparam int CLK_NS  = 10;
  localparam int T_ACC   = 45;
  localparam int T_OE    = 25;
  localparam int T_DF    = 25;
  localparam int CE_EXP  = (T_ACC + CLK_NS - 1) / CLK_NS;   // 5
  localparam int OE_EXP  = (T_OE + CLK_NS - 1) / CLK_NS;    // 3
  localparam int DF_EXP  = (T_DF + CLK_NS - 1) / CLK_NS;    // 3

  logic       clk = 1'b0;
  logic       rst;
  logic       reqValid;
  logic       reqReady;
  logic [9:0] reqAddr;
  logic       rspValid;
  logic [7:0] rspData;
  logic [7:0] memAddr;
  logic [3:0] memCeN;
  logic       memOeN;
  logic [7:0] memData = 8'hEE;

  int tests  = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  byte_mem_reader u_byte_mem_reader (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .rspData  (rspData),
    .memAddr  (memAddr),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memData  (memData)
  );

  function automatic logic [7:0] romByte(input logic [1:0] dev, input logic [7:0] a);
    return a ^ (8'h3B * {6'd0, dev}) ^ 8'h5A;
  endfunction

  // Memory bank model: returns true data only once every delay has elapsed
  time        tCe = 0, tOe = 0, tAd = 0;
  logic [3:0] pCeN = 4'hF;
  logic       pOeN = 1'b1;
  logic [7:0] pAd  = 8'h00;
  always begin
    #1;
    if (memCeN !== pCeN) tCe = $time;
    if (memOeN !== pOeN) tOe = $time;
    if (memAddr !== pAd) tAd = $time;
    pCeN = memCeN; pOeN = memOeN; pAd = memAddr;
    memData = 8'hEE;
    if (memOeN === 1'b0 && ($time - tCe) >= T_ACC && ($time - tOe) >= T_OE &&
        ($time - tAd) >= T_ACC) begin
      for (int d = 0; d < 4; d++)
        if (memCeN === ~(4'b0001 << d)) memData = romByte(2'(d), memAddr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One read; returns the number of cycles spent waiting for ready
  task automatic readOnce(input logic [9:0] a, output int waits);
    int ceLow = 0, oeLow = 0, cyc = 0;
    bit badCe = 0, badOe = 0, badAd = 0, badRdy = 0, gotRsp = 0;
    logic [3:0] expCe = ~(4'b0001 << a[9:8]);
    reqAddr  = a;
    reqValid = 1'b1;
    #1;
    waits = 0;
    while (!reqReady && waits < 100) begin
      @(negedge clk); #1; waits++;
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
    while (cyc < 40) begin
      @(negedge clk); cyc++;
      if (rspValid) begin gotRsp = 1; break; end
      if (!(&memCeN)) begin
        ceLow++;
        if (memCeN !== expCe) badCe = 1;
        if (memAddr !== a[7:0]) badAd = 1;
      end
      if (!memOeN) begin
        oeLow++;
        if (&memCeN) badOe = 1;
      end
      if (reqReady) badRdy = 1;
    end
    chk(gotRsp, "R5", "response seen", gotRsp, 1);
    chk(rspData == romByte(a[9:8], a[7:0]), "R5", "read data", rspData, romByte(a[9:8], a[7:0]));
    chk(ceLow == CE_EXP, "R3/R4", "enable window cycles", ceLow, CE_EXP);
    chk(oeLow == OE_EXP, "R3/R4", "output-enable cycles", oeLow, OE_EXP);
    chk(!badCe, "R1", "selected device pattern", badCe, 0);
    chk(!badOe, "R2", "output enable outside select", badOe, 0);
    chk(!badAd, "R8", "address stable", badAd, 0);
    chk(!badRdy, "R6", "ready low while busy", badRdy, 0);
    chk(&memCeN && memOeN, "R3", "release at sample", {memCeN, memOeN}, 5'h1F);
  endtask

  task automatic testReset();
    chk(memCeN == 4'hF, "R8", "reset enables", memCeN, 4'hF);
    chk(memOeN == 1'b1, "R8", "reset output enable", memOeN, 1);
    chk(memAddr == 8'h00, "R8", "reset address", memAddr, 0);
    chk(rspValid == 1'b0, "R8", "reset valid", rspValid, 0);
  endtask

  task automatic testEachDevice();
    int w;
    logic [9:0] addrs [4] = '{10'h000, 10'h1A5, 10'h2FF, 10'h37C};
    foreach (addrs[i]) begin
      readOnce(addrs[i], w);   // R1 decode per device, R3 R4 timing
      @(negedge clk);
      chk(!rspValid, "R5", "valid single pulse", rspValid, 0);
      chk(&memCeN, "R1", "idle all deselected", memCeN, 4'hF);
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic testSameDevice();
    int w;
    readOnce(10'h210, w);
    readOnce(10'h2C3, w);
    chk(w == 0, "R7", "same device wait cycles", w, 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic testOtherDevice();
    int w;
    readOnce(10'h0F0, w);
    readOnce(10'h3F0, w);
    chk(w + 1 == DF_EXP, "R7", "float gap cycles", w + 1, DF_EXP);
    readOnce(10'h1F0, w);
    chk(w + 1 == DF_EXP, "R7", "float gap second pair", w + 1, DF_EXP);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; reqValid = 1'b0; reqAddr = '0;
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(memCeN == 4'hF, "R1", "idle after reset", memCeN, 4'hF);
    testEachDevice();
    testSameDevice();
    testOtherDevice();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule